// File: doc/BRIEF.md
# Two-Input Priority Multiplexer with Bounded Starvation

This block is one node of a binary memory-request tree. It takes request packets from two children, one favoured (high priority) and one deferred (low priority), and forwards at most one packet per cycle into a registered upstream output. All three request channels use valid/ready handshakes. The node never leaves a slot unused: if either child offers a packet and the output register can take one, a packet moves.

Plain strict priority could starve the low-priority child. A saturating win counter prevents this. It counts high-priority relays that happen while a low-priority packet waits. At its limit it hands the next slot to the low-priority child. The counter moves only in cycles where a packet actually enters the output register.

Each relayed packet gets one routing bit appended below its source tag, so a tree of these nodes builds a leaf index as the request climbs. Responses coming back down are demultiplexed by the lowest tag bit. The tag is shifted right by one so that the child node sees its own bit at position 0.

Top module: `prio_mux_node`

## Requirements
- R1: After reset the upstream output is empty (`up_valid` low) and the win counter is zero, so the first contention goes to the high-priority child.
- R2: When the output register can load and the high-priority child is valid, it is granted unless the low-priority child is also valid with the counter at its limit. A grant is signalled by the matching input ready.
- R3: While a low-priority packet waits and the output keeps accepting, at most BLOCK_M-1 (default 3) high-priority packets are relayed before it.
- R4: With both children valid and the counter at BLOCK_M-1, the low-priority child is relayed and the high-priority child is held for that slot.
- R5: The counter changes only in cycles where a packet is loaded into the output register. Stalled or idle cycles leave the grant sequence where it was.
- R6: Work conservation: if any child is valid and the output register is empty or being drained this cycle, exactly one input ready is high. When the output cannot load, both readies are low.
- R7: When only the low-priority child is valid, it is relayed at once, whatever the counter value.
- R8: The relayed packet appears on `up_data` one cycle after the handshake. `up_tag` is {child tag, source bit}, where the source bit (bit 0) is 0 for the high-priority child and 1 for the low-priority child.
- R9: While `up_valid` is high and `up_ready` is low, `up_valid`, `up_data` and `up_tag` hold, and no input is granted.
- R10: A response with `rsp_tag[0]`=0 goes to the high-priority side and one with `rsp_tag[0]`=1 goes to the low-priority side, in the same cycle. The outgoing tag is `rsp_tag` shifted right by one, the data is unchanged, and the other side's valid stays low.
- R11: A low-priority relay clears the counter, so the next contention again gives the high-priority child BLOCK_M-1 wins. A high-priority relay with no low-priority packet waiting leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_valid | input | 1 | High-priority child offers a packet |
| hi_ready | output | 1 | High-priority packet accepted this cycle |
| hi_data | input | DATA_W | High-priority packet payload |
| hi_tag | input | TAG_W | High-priority packet source tag |
| lo_valid | input | 1 | Low-priority child offers a packet |
| lo_ready | output | 1 | Low-priority packet accepted this cycle |
| lo_data | input | DATA_W | Low-priority packet payload |
| lo_tag | input | TAG_W | Low-priority packet source tag |
| up_valid | output | 1 | Output register holds a packet |
| up_ready | input | 1 | Upstream accepts the held packet |
| up_data | output | DATA_W | Forwarded payload |
| up_tag | output | TAG_W+1 | Forwarded tag with source bit at bit 0 |
| rsp_valid | input | 1 | Response arriving from upstream |
| rsp_data | input | RSP_W | Response payload |
| rsp_tag | input | TAG_W+1 | Response routing tag |
| rsp_hi_valid | output | 1 | Response for the high-priority child |
| rsp_hi_data | output | RSP_W | Response payload to high-priority child |
| rsp_hi_tag | output | TAG_W | Shifted tag to high-priority child |
| rsp_lo_valid | output | 1 | Response for the low-priority child |
| rsp_lo_data | output | RSP_W | Response payload to low-priority child |
| rsp_lo_tag | output | TAG_W | Shifted tag to low-priority child |

## Verification
The bench targets continuous contention. In that case a node without the counter limit would starve the low-priority child, and a counter that was off by one would let through a fourth high-priority packet or hand over the slot too early. It holds contention through long upstream stalls; a counter that counted idle or stalled cycles would move the hand-over point. It also offers lone low-priority packets while the counter sits at its limit, and expects them to pass at once rather than be delayed. Inverted or misplaced source bits show up as wrong upstream tags. A demultiplexer that routed on the wrong bit or forgot the shift shows up as wrong response routing or wrong tags.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
    typedef enum logic [1:0] {
        GNT_NONE = 2'd0,
        GNT_HI   = 2'd1,
        GNT_LO   = 2'd2
    } gnt_e;
endpackage

// File: rtl/pmx_arb.sv
module pmx_arb
    import pmx_pkg::*;
#(
    parameter int BLOCK_M = 4,
    localparam int CNT_W = (BLOCK_M > 1) ? $clog2(BLOCK_M) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_valid,
    input  logic             lo_valid,
    input  logic             can_load,
    output gnt_e             gnt,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BLOCK_M - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        gnt  = GNT_NONE;
        st_d = st_q;
        if (can_load) begin
            if (hi_valid && lo_valid) begin
                gnt = (st_q.cnt == LIMIT) ? GNT_LO : GNT_HI;
            end else if (hi_valid) begin
                gnt = GNT_HI;
            end else if (lo_valid) begin
                gnt = GNT_LO;
            end
        end
        // counter only moves on an actual relay
        if (gnt == GNT_LO) begin
            st_d.cnt = '0;
        end else if (gnt == GNT_HI && lo_valid && st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/pmx_out_reg.sv
module pmx_out_reg #(
    parameter int DATA_W = 32,
    parameter int OTAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] in_data,
    input  logic [OTAG_W-1:0] in_tag,
    input  logic              up_ready,
    output logic              up_valid,
    output logic [DATA_W-1:0] up_data,
    output logic [OTAG_W-1:0] up_tag,
    output logic              can_load
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [OTAG_W-1:0] tag;
    } oreg_t;

    oreg_t r_d, r_q;

    always_comb begin
        can_load = !r_q.valid || up_ready;
        r_d      = r_q;
        if (can_load) begin
            r_d.valid = load;
            if (load) begin
                r_d.data = in_data;
                r_d.tag  = in_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign up_valid = r_q.valid;
    assign up_data  = r_q.data;
    assign up_tag   = r_q.tag;
endmodule

// File: rtl/pmx_rsp_demux.sv
module pmx_rsp_demux #(
    parameter int RSP_W = 32,
    parameter int TAG_W = 3
) (
    input  logic             rsp_valid,
    input  logic [RSP_W-1:0] rsp_data,
    input  logic [TAG_W:0]   rsp_tag,
    output logic             rsp_hi_valid,
    output logic [RSP_W-1:0] rsp_hi_data,
    output logic [TAG_W-1:0] rsp_hi_tag,
    output logic             rsp_lo_valid,
    output logic [RSP_W-1:0] rsp_lo_data,
    output logic [TAG_W-1:0] rsp_lo_tag
);
    logic [TAG_W-1:0] tag_sh;

    always_comb begin
        tag_sh       = rsp_tag[TAG_W:1];
        rsp_hi_valid = rsp_valid && !rsp_tag[0];
        rsp_lo_valid = rsp_valid &&  rsp_tag[0];
        rsp_hi_data  = rsp_data;
        rsp_lo_data  = rsp_data;
        rsp_hi_tag   = tag_sh;
        rsp_lo_tag   = tag_sh;
    end
endmodule

// File: rtl/prio_mux_node.sv
module prio_mux_node
    import pmx_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 3,
    parameter int RSP_W   = 32,
    parameter int BLOCK_M = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_valid,
    output logic              hi_ready,
    input  logic [DATA_W-1:0] hi_data,
    input  logic [TAG_W-1:0]  hi_tag,
    input  logic              lo_valid,
    output logic              lo_ready,
    input  logic [DATA_W-1:0] lo_data,
    input  logic [TAG_W-1:0]  lo_tag,
    output logic              up_valid,
    input  logic              up_ready,
    output logic [DATA_W-1:0] up_data,
    output logic [TAG_W:0]    up_tag,
    input  logic              rsp_valid,
    input  logic [RSP_W-1:0]  rsp_data,
    input  logic [TAG_W:0]    rsp_tag,
    output logic              rsp_hi_valid,
    output logic [RSP_W-1:0]  rsp_hi_data,
    output logic [TAG_W-1:0]  rsp_hi_tag,
    output logic              rsp_lo_valid,
    output logic [RSP_W-1:0]  rsp_lo_data,
    output logic [TAG_W-1:0]  rsp_lo_tag
);
    localparam int CNT_W  = (BLOCK_M > 1) ? $clog2(BLOCK_M) : 1;
    localparam int OTAG_W = TAG_W + 1;

    gnt_e              gnt;
    logic [CNT_W-1:0]  blk_cnt;
    logic              can_load;
    logic [DATA_W-1:0] sel_data;
    logic [OTAG_W-1:0] sel_tag;

    pmx_arb #(.BLOCK_M(BLOCK_M)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_valid (hi_valid),
        .lo_valid (lo_valid),
        .can_load (can_load),
        .gnt      (gnt),
        .cnt      (blk_cnt)
    );

    always_comb begin
        hi_ready = (gnt == GNT_HI);
        lo_ready = (gnt == GNT_LO);
        if (gnt == GNT_LO) begin
            sel_data = lo_data;
            sel_tag  = {lo_tag, 1'b1};
        end else begin
            sel_data = hi_data;
            sel_tag  = {hi_tag, 1'b0};
        end
    end

    pmx_out_reg #(.DATA_W(DATA_W), .OTAG_W(OTAG_W)) u_oreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gnt != GNT_NONE),
        .in_data  (sel_data),
        .in_tag   (sel_tag),
        .up_ready (up_ready),
        .up_valid (up_valid),
        .up_data  (up_data),
        .up_tag   (up_tag),
        .can_load (can_load)
    );

    pmx_rsp_demux #(.RSP_W(RSP_W), .TAG_W(TAG_W)) u_rsp (
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .rsp_tag      (rsp_tag),
        .rsp_hi_valid (rsp_hi_valid),
        .rsp_hi_data  (rsp_hi_data),
        .rsp_hi_tag   (rsp_hi_tag),
        .rsp_lo_valid (rsp_lo_valid),
        .rsp_lo_data  (rsp_lo_data),
        .rsp_lo_tag   (rsp_lo_tag)
    );
endmodule

// File: rtl/pmx_node_chk.sv
module pmx_node_chk #(
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 3,
    parameter int BLOCK_M = 4,
    localparam int CNT_W  = (BLOCK_M > 1) ? $clog2(BLOCK_M) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hi_valid,
    input logic              hi_ready,
    input logic              lo_valid,
    input logic              lo_ready,
    input logic              up_valid,
    input logic              up_ready,
    input logic [DATA_W-1:0] up_data,
    input logic [TAG_W:0]    up_tag,
    input logic              rsp_hi_valid,
    input logic              rsp_lo_valid,
    input logic [CNT_W-1:0]  blk_cnt
);
    logic hi_fire, lo_fire;
    logic [CNT_W:0] ovt_q;

    assign hi_fire = hi_valid && hi_ready;
    assign lo_fire = lo_valid && lo_ready;

    // independent tally of overtakes suffered by a waiting low-priority packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovt_q <= '0;
        end else if (lo_fire) begin
            ovt_q <= '0;
        end else if (hi_fire && lo_valid && ovt_q != {(CNT_W+1){1'b1}}) begin
            ovt_q <= ovt_q + 1'b1;
        end
    end

    assert_lo_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ovt_q) <= BLOCK_M - 1);

    assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_ready && lo_ready));

    assert_work_cons_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_valid || lo_valid) && (!up_valid || up_ready)) |-> (hi_fire || lo_fire));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_ready) |=> (up_valid && $stable(up_data) && $stable(up_tag)));

    assert_no_grant_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_ready) |-> !(hi_ready || lo_ready));

    assert_cnt_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_fire || lo_fire) |=> $stable(blk_cnt));

    assert_src_bit_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_fire |=> (up_valid && !up_tag[0]));

    assert_src_bit_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lo_fire |=> (up_valid && up_tag[0]));

    assert_rsp_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hi_valid, rsp_lo_valid}));
endmodule

bind prio_mux_node pmx_node_chk #(
    .DATA_W  (DATA_W),
    .TAG_W   (TAG_W),
    .BLOCK_M (BLOCK_M)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hi_valid     (hi_valid),
    .hi_ready     (hi_ready),
    .lo_valid     (lo_valid),
    .lo_ready     (lo_ready),
    .up_valid     (up_valid),
    .up_ready     (up_ready),
    .up_data      (up_data),
    .up_tag       (up_tag),
    .rsp_hi_valid (rsp_hi_valid),
    .rsp_lo_valid (rsp_lo_valid),
    .blk_cnt      (blk_cnt)
);

// File: tb/prio_mux_node_test.sv
module prio_mux_node_test;
    localparam int DW = 32;
    localparam int TW = 3;
    localparam int RW = 32;
    localparam int M  = 4;

    logic clk = 0;
    logic rst_n = 0;
    always #2 clk = ~clk;

    logic hi_valid = 0, lo_valid = 0, up_ready = 0, rsp_valid = 0;
    logic [DW-1:0] hi_data = 0, lo_data = 0;
    logic [TW-1:0] hi_tag = 0, lo_tag = 0;
    logic [RW-1:0] rsp_data = 0;
    logic [TW:0]   rsp_tag = 0;
    logic hi_ready, lo_ready, up_valid, rsp_hi_valid, rsp_lo_valid;
    logic [DW-1:0] up_data;
    logic [TW:0]   up_tag;
    logic [RW-1:0] rsp_hi_data, rsp_lo_data;
    logic [TW-1:0] rsp_hi_tag, rsp_lo_tag;

    prio_mux_node #(.DATA_W(DW), .TAG_W(TW), .RSP_W(RW), .BLOCK_M(M)) uut (.*);

    int tests = 0, fails = 0;
    bit done = 0;
    int m_cnt = 0;
    bit m_v = 0;
    logic [DW-1:0] m_d = 0;
    logic [TW:0] m_t = 0;
    int obs_g = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected grant: 0 none, 1 high, 2 low
    function automatic int exp_pick(bit hv, bit lv, int c);
        if (hv && lv) return (c == M - 1) ? 2 : 1;
        if (hv) return 1;
        if (lv) return 2;
        return 0;
    endfunction

    task automatic cycle(bit hv, bit lv, bit ur);
        bit can;
        int g;
        string req;
        @(negedge clk);
        hi_valid = hv; lo_valid = lv; up_ready = ur;
        hi_data = $urandom; lo_data = $urandom;
        hi_tag = TW'($urandom); lo_tag = TW'($urandom);
        rsp_valid = 1'($urandom); rsp_data = $urandom; rsp_tag = (TW+1)'($urandom);
        #1;
        can = !m_v || ur;
        g = can ? exp_pick(hv, lv, m_cnt) : 0;
        if (!can) req = "R9";
        else if (hv && lv && m_cnt == M - 1) req = "R4";
        else if (lv && !hv) req = "R7";
        else if (g == 1) req = "R2";
        else req = "R6";
        obs_g = hi_ready ? 1 : (lo_ready ? 2 : 0);
        chk(hi_ready == (g == 1), req, "hi_ready", hi_ready, g == 1);
        chk(lo_ready == (g == 2), req, "lo_ready", lo_ready, g == 2);
        chk(rsp_hi_valid == (rsp_valid && !rsp_tag[0]), "R10", "rsp_hi_valid", rsp_hi_valid, rsp_valid && !rsp_tag[0]);
        chk(rsp_lo_valid == (rsp_valid && rsp_tag[0]), "R10", "rsp_lo_valid", rsp_lo_valid, rsp_valid && rsp_tag[0]);
        if (rsp_valid) begin
            chk((rsp_tag[0] ? rsp_lo_tag : rsp_hi_tag) == rsp_tag[TW:1], "R10", "rsp tag",
                rsp_tag[0] ? rsp_lo_tag : rsp_hi_tag, rsp_tag[TW:1]);
            chk((rsp_tag[0] ? rsp_lo_data : rsp_hi_data) == rsp_data, "R10", "rsp data",
                rsp_tag[0] ? rsp_lo_data : rsp_hi_data, rsp_data);
        end
        @(posedge clk);
        if (can) begin
            m_v = (g != 0);
            if (g == 1) begin m_d = hi_data; m_t = {hi_tag, 1'b0}; end
            if (g == 2) begin m_d = lo_data; m_t = {lo_tag, 1'b1}; end
        end
        if (g == 2) m_cnt = 0;
        else if (g == 1 && lv && m_cnt != M - 1) m_cnt++;
        #1;
        chk(up_valid == m_v, can ? "R8" : "R9", "up_valid", up_valid, m_v);
        if (m_v) begin
            chk(up_data == m_d, can ? "R8" : "R9", "up_data", up_data, m_d);
            chk(up_tag == m_t, can ? "R8" : "R9", "up_tag", up_tag, m_t);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        rst_n = 1;
        #1;
        chk(up_valid == 0, "R1", "up_valid after reset", up_valid, 0);

        // R1 / R3 / R4 / R11: continuous contention -> H H H L H H H L
        n = 0;
        for (int i = 0; i < 8; i++) begin
            cycle(1, 1, 1);
            if (i == 0) chk(obs_g == 1, "R1", "first contention grant", obs_g, 1);
            if (obs_g == 1) n++;
            if (i == 3 || i == 7) begin
                chk(obs_g == 2, "R3", "lo after M-1 overtakes", obs_g, 2);
                chk(n == M - 1, "R3", "overtake count", n, M - 1);
                n = 0;
            end
            if (i == 4) chk(obs_g == 1, "R11", "hi regains after lo relay", obs_g, 1);
        end

        // R5: two hi wins, then long stall under contention, then resume
        cycle(1, 1, 1);
        cycle(1, 1, 1);
        for (int i = 0; i < 6; i++) cycle(1, 1, 0);
        cycle(1, 1, 1);
        chk(obs_g == 1, "R5", "third hi win after stall", obs_g, 1);
        cycle(1, 1, 1);
        chk(obs_g == 2, "R5", "lo slot after stall", obs_g, 2);

        // R7: counter to limit, then lone lo passes at once
        for (int i = 0; i < 3; i++) cycle(1, 1, 1);
        cycle(0, 1, 1);
        chk(obs_g == 2, "R7", "lone lo at limit", obs_g, 2);

        // R11: hi relays without lo waiting leave counter alone
        for (int i = 0; i < 2; i++) cycle(1, 1, 1);
        for (int i = 0; i < 5; i++) cycle(1, 0, 1);
        cycle(1, 1, 1);
        chk(obs_g == 1, "R11", "hi win held count", obs_g, 1);
        cycle(1, 1, 1);
        chk(obs_g == 2, "R11", "lo after held count", obs_g, 2);

        // random mix
        for (int i = 0; i < 3000; i++)
            cycle(1'($urandom), 1'($urandom), ($urandom % 4) != 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule